// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block takes a set of DDR SDRAM ranks from power-up to normal operation. A one-cycle start pulse launches a fixed fifteen-step series of commands. Each step first sets the controller mode code. It then walks the ranks in ascending order and sends the command to every populated rank as a single address strobe. After each step the block waits a programmed number of cycles before the next step begins.

The populated ranks come from a flat vector of rank end boundaries in 32 MB units. A rank receives a command only when its end boundary lies above the running start, which is the end of the last rank that received one. The strobe address is that running start shifted into 32 MB units, plus the mode bits for the two mode-register commands. The final step switches the controller into normal mode and sends nothing to the ranks. One step-wait later the block raises its init-complete flag and drops busy. It then ignores any further start until reset.

Top module: `ddr_powerup_seq`

## Requirements
- R1: After reset, busy, initDone and cmdValid are 0 and modeSel is 0.
- R2: modeSel uses the 3-bit codes NOP=1, precharge-all=2, mode-set=3, extended-mode-set=4, auto-refresh=6 and normal=7. The steps run in this order: NOP, precharge-all, extended-mode-set, mode-set, precharge-all, REFRESH_COUNT (8) auto-refreshes, mode-set, normal.
- R3: The first mode-set carries MRS_WORD with bit 8 (DLL reset) set. The second carries MRS_WORD unchanged. The default MRS_WORD of 0x06A encodes burst length 4, interleaved burst and CAS latency 2.5. The extended-mode-set carries EMRS_WORD, whose default of 0 keeps the DLL enabled.
- R4: For mode-set and extended-mode-set, mode-word bit 11 drives address bit 13, bits 9:0 drive address bits 12:3, and bit 10 is dropped. All other commands use a mode offset of 0.
- R5: Within a step, rank r receives a command (cmdValid=1, cmdRank=r) exactly when its end exceeds the running start. The running start begins at 0 in each step and becomes that rank's end. cmdAddr is {running start, 25-bit mode offset}.
- R6: A rank whose end does not exceed the running start gets no command. With all ends at 0 the series issues no command and still completes.
- R7: No command is sent while modeSel is normal (7).
- R8: Rank r is examined in scan cycle r+1 of its step. After the last rank, the block waits LONG_WAIT cycles following the NOP step and STEP_WAIT cycles following every other step, and only then does the next step start.
- R9: initDone rises exactly STEP_WAIT cycles after modeSel turns normal. busy falls on the same edge. initDone then stays at 1.
- R10: busy and modeSel=NOP appear one edge after start is sampled. start is ignored while busy and after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the series |
| rankEnds | input | NUM_RANKS*END_W (32) | Rank end boundaries in 32 MB units; rank r at bits r*END_W upward |
| modeSel | output | 3 | Current controller mode code |
| cmdValid | output | 1 | One-cycle strobe: command sent to a rank |
| cmdRank | output | RANK_W (2) | Rank index of the strobe |
| cmdAddr | output | END_W+UNIT_SHIFT (33) | Strobe address: rank base plus mode offset |
| busy | output | 1 | High from start until completion |
| initDone | output | 1 | Set after normal mode has been entered |

## Verification
A wrong step counter or mode code shows up at once as a strobe carrying the wrong modeSel or the wrong mode offset. A skipped or repeated step changes the number of strobes and moves the completion time. A stale running start shows on the very next strobe as a wrong rank base, or as a command going to a rank that should have been skipped. A wait counter that is off by one shows in the spacing between the last strobe of one step and the first strobe of the next, so the bench measures every such gap. The last gap appears as the distance from modeSel turning normal to initDone rising.

// File: rtl/ddr_powerup_seq_pkg.sv
package ddr_powerup_seq_pkg;

  typedef enum logic [2:0] {
    CMD_SELF_REF  = 3'd0,
    CMD_NOP       = 3'd1,
    CMD_PRECHARGE = 3'd2,
    CMD_MRS       = 3'd3,
    CMD_EMRS      = 3'd4,
    CMD_REFRESH   = 3'd6,
    CMD_NORMAL    = 3'd7
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic scanClr;  // restart the running start at zero
    logic scanEn;   // examine the addressed rank this cycle
    logic mapMode;  // place mode bits on the address
  } ctrl_strobes_t;

endpackage

// File: rtl/ddr_powerup_seq_ctrl.sv
module ddr_powerup_seq_ctrl
  import ddr_powerup_seq_pkg::*;
#(
  parameter int NUM_RANKS     = 4,
  parameter int LONG_WAIT     = 40,
  parameter int STEP_WAIT     = 6,
  parameter int REFRESH_COUNT = 8,
  parameter logic [11:0] MRS_WORD  = 12'h06A,
  parameter logic [11:0] EMRS_WORD = 12'h000,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int STEP_W = $clog2(7 + REFRESH_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output ctrl_strobes_t     strb,
  output logic [RANK_W-1:0] rankIdx,
  output logic [10:0]       pinBits,
  output logic [2:0]        modeSel,
  output logic              busy,
  output logic              initDone
);

  localparam int MAX_WAIT = (LONG_WAIT > STEP_WAIT) ? LONG_WAIT : STEP_WAIT;
  localparam int CNT_W = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] LONG_LOAD = CNT_W'(LONG_WAIT - 1);
  localparam logic [CNT_W-1:0] STEP_LOAD = CNT_W'(STEP_WAIT - 1);
  localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_RANKS - 1);
  localparam logic [STEP_W-1:0] S_NOP   = STEP_W'(0);
  localparam logic [STEP_W-1:0] S_PRE1  = STEP_W'(1);
  localparam logic [STEP_W-1:0] S_EMRS  = STEP_W'(2);
  localparam logic [STEP_W-1:0] S_MRS1  = STEP_W'(3);
  localparam logic [STEP_W-1:0] S_PRE2  = STEP_W'(4);
  localparam logic [STEP_W-1:0] S_CBRL  = STEP_W'(4 + REFRESH_COUNT);
  localparam logic [STEP_W-1:0] S_MRS2  = STEP_W'(5 + REFRESH_COUNT);
  localparam logic [STEP_W-1:0] S_LAST  = STEP_W'(6 + REFRESH_COUNT);
  localparam logic [11:0] DLL_RESET = 12'h100;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} state_e;

  state_e state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] nextStep;
  logic [CNT_W-1:0]  cnt;
  logic              advance;
  logic [11:0]       modeWord;

  function automatic cmd_e stepCode(input logic [STEP_W-1:0] s);
    if (s == S_NOP)                     return CMD_NOP;
    else if (s == S_PRE1 || s == S_PRE2) return CMD_PRECHARGE;
    else if (s == S_EMRS)               return CMD_EMRS;
    else if (s == S_MRS1 || s == S_MRS2) return CMD_MRS;
    else if (s <= S_CBRL)               return CMD_REFRESH;
    else                                return CMD_NORMAL;
  endfunction

  always_comb begin
    if (step == S_EMRS)      modeWord = EMRS_WORD;
    else if (step == S_MRS1) modeWord = MRS_WORD | DLL_RESET;
    else if (step == S_MRS2) modeWord = MRS_WORD;
    else                     modeWord = 12'h000;
  end

  assign pinBits      = {modeWord[11], modeWord[9:0]};
  assign nextStep     = step + STEP_W'(1);
  assign advance      = (state == ST_WAIT) && (cnt == '0);
  assign strb.scanEn  = (state == ST_ISSUE);
  assign strb.scanClr = ((state == ST_IDLE) && start) || advance;
  assign strb.mapMode = (modeSel == CMD_MRS) || (modeSel == CMD_EMRS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      step     <= '0;
      rankIdx  <= '0;
      cnt      <= '0;
      modeSel  <= CMD_SELF_REF;
      busy     <= 1'b0;
      initDone <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_ISSUE;
          step    <= S_NOP;
          rankIdx <= '0;
          modeSel <= CMD_NOP;
          busy    <= 1'b1;
        end
        ST_ISSUE: begin
          if (rankIdx == LAST_RANK) begin
            rankIdx <= '0;
            state   <= ST_WAIT;
            cnt     <= (step == S_NOP) ? LONG_LOAD : STEP_LOAD;
          end else begin
            rankIdx <= rankIdx + RANK_W'(1);
          end
        end
        ST_WAIT: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (step == S_LAST) begin
            state    <= ST_DONE;
            busy     <= 1'b0;
            initDone <= 1'b1;
          end else begin
            step    <= nextStep;
            modeSel <= stepCode(nextStep);
            if (nextStep == S_LAST) begin
              state <= ST_WAIT;
              cnt   <= STEP_LOAD;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ddr_powerup_seq_dp.sv
module ddr_powerup_seq_dp
  import ddr_powerup_seq_pkg::*;
#(
  parameter int NUM_RANKS  = 4,
  parameter int END_W      = 8,
  parameter int UNIT_SHIFT = 25,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int ADDR_W = END_W + UNIT_SHIFT
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobes_t              strb,
  input  logic [RANK_W-1:0]          rankIdx,
  input  logic [10:0]                pinBits,
  input  logic [NUM_RANKS*END_W-1:0] rankEnds,
  output logic                       cmdValid,
  output logic [RANK_W-1:0]          cmdRank,
  output logic [ADDR_W-1:0]          cmdAddr
);

  logic [END_W-1:0]      endArr [NUM_RANKS];
  logic [END_W-1:0]      runStart;
  logic [END_W-1:0]      curEnd;
  logic [UNIT_SHIFT-1:0] modeOff;
  logic                  hit;

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_ends
    assign endArr[g] = rankEnds[g*END_W +: END_W];
  end

  assign curEnd = endArr[rankIdx];
  assign hit    = strb.scanEn && (curEnd > runStart);

  always_comb begin
    modeOff = '0;
    if (strb.mapMode) begin
      modeOff[13]   = pinBits[10];
      modeOff[12:3] = pinBits[9:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runStart <= '0;
      cmdValid <= 1'b0;
      cmdRank  <= '0;
      cmdAddr  <= '0;
    end else begin
      cmdValid <= hit;
      if (strb.scanClr) begin
        runStart <= '0;
      end else if (hit) begin
        runStart <= curEnd;
        cmdRank  <= rankIdx;
        cmdAddr  <= {runStart, modeOff};
      end
    end
  end

endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
  import ddr_powerup_seq_pkg::*;
#(
  parameter int NUM_RANKS     = 4,
  parameter int END_W         = 8,
  parameter int UNIT_SHIFT    = 25,
  parameter int LONG_WAIT     = 40,
  parameter int STEP_WAIT     = 6,
  parameter int REFRESH_COUNT = 8,
  parameter logic [11:0] MRS_WORD  = 12'h06A,
  parameter logic [11:0] EMRS_WORD = 12'h000,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int ADDR_W = END_W + UNIT_SHIFT
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [NUM_RANKS*END_W-1:0] rankEnds,
  output logic [2:0]                 modeSel,
  output logic                       cmdValid,
  output logic [RANK_W-1:0]          cmdRank,
  output logic [ADDR_W-1:0]          cmdAddr,
  output logic                       busy,
  output logic                       initDone
);

  ctrl_strobes_t     strb;
  logic [RANK_W-1:0] rankIdx;
  logic [10:0]       pinBits;

  ddr_powerup_seq_ctrl #(
    .NUM_RANKS(NUM_RANKS), .LONG_WAIT(LONG_WAIT), .STEP_WAIT(STEP_WAIT),
    .REFRESH_COUNT(REFRESH_COUNT), .MRS_WORD(MRS_WORD), .EMRS_WORD(EMRS_WORD)
  ) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb), .rankIdx(rankIdx),
    .pinBits(pinBits), .modeSel(modeSel), .busy(busy), .initDone(initDone)
  );

  ddr_powerup_seq_dp #(
    .NUM_RANKS(NUM_RANKS), .END_W(END_W), .UNIT_SHIFT(UNIT_SHIFT)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rankIdx(rankIdx), .pinBits(pinBits),
    .rankEnds(rankEnds), .cmdValid(cmdValid), .cmdRank(cmdRank), .cmdAddr(cmdAddr)
  );

endmodule

// File: rtl/ddr_powerup_seq_chk.sv
module ddr_powerup_seq_chk #(
  parameter int RANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        modeSel,
  input logic              cmdValid,
  input logic [RANK_W-1:0] cmdRank,
  input logic              busy,
  input logic              initDone
);

  assert_no_cmd_in_normal_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (modeSel != 3'd7));

  assert_done_after_normal_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (modeSel == 3'd7));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  assert_busy_excl_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && initDone));

  assert_cmd_only_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);

  assert_rank_ascending_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && $past(cmdValid) && $stable(modeSel)) |-> (cmdRank > $past(cmdRank)));

  assert_mode_stable_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(modeSel));

endmodule

bind ddr_powerup_seq ddr_powerup_seq_chk #(.RANK_W(RANK_W)) chkInst (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .cmdValid(cmdValid),
  .cmdRank(cmdRank), .busy(busy), .initDone(initDone)
);

// File: tb/ddr_powerup_seq_test.sv
module ddr_powerup_seq_test;

  localparam int NR = 4;
  localparam int EW = 8;
  localparam int US = 25;
  localparam int LW = 20;
  localparam int SW = 5;
  localparam int RC = 8;
  localparam logic [11:0] MRSW  = 12'h06A;
  localparam logic [11:0] EMRSW = 12'hC00;
  localparam int NSTEP = 6 + RC;  // steps that send commands

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NR*EW-1:0] rankEnds = '0;
  logic [2:0] modeSel;
  logic cmdValid;
  logic [1:0] cmdRank;
  logic [EW+US-1:0] cmdAddr;
  logic busy, initDone;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ddr_powerup_seq #(
    .NUM_RANKS(NR), .END_W(EW), .UNIT_SHIFT(US), .LONG_WAIT(LW),
    .STEP_WAIT(SW), .REFRESH_COUNT(RC), .MRS_WORD(MRSW), .EMRS_WORD(EMRSW)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .rankEnds(rankEnds),
    .modeSel(modeSel), .cmdValid(cmdValid), .cmdRank(cmdRank),
    .cmdAddr(cmdAddr), .busy(busy), .initDone(initDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // R2: step codes
  function automatic int expCode(input int j);
    if (j == 0) return 1;
    if (j == 1 || j == 4) return 2;
    if (j == 2) return 4;
    if (j == 3 || j == 5 + RC) return 3;
    return 6;
  endfunction

  // R3/R4: mapped mode offset
  function automatic longint expOff(input int j);
    logic [11:0] w;
    if (j == 2) w = EMRSW;
    else if (j == 3) w = MRSW | 12'h100;
    else if (j == 5 + RC) w = MRSW;
    else return 0;
    return (longint'(w[11]) << 13) | (longint'(w[9:0]) << 3);
  endfunction

  task automatic doReset();
    start = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(initDone == 1'b0, "R1", "initDone after reset", initDone, 0);
    check(cmdValid == 1'b0, "R1", "cmdValid after reset", cmdValid, 0);
    check(modeSel == 3'd0, "R1", "modeSel after reset", modeSel, 0);
  endtask

  // Runs the whole series and compares every strobe and gap with a model.
  task automatic runSeq(input logic [7:0] e0, input logic [7:0] e1,
                        input logic [7:0] e2, input logic [7:0] e3,
                        input int injectAt, input string tag);
    logic [7:0] ends [NR];
    int  eCode[64], eRank[64], eStep[64];
    longint eAddr[64];
    int  aCode[64], aRank[64], aCyc[64];
    longint aAddr[64];
    int nExp = 0, nAct = 0, t7 = -1, tDone = -1;
    bit badNormal = 0;
    ends[0] = e0; ends[1] = e1; ends[2] = e2; ends[3] = e3;
    doReset();
    rankEnds = {e3, e2, e1, e0};
    for (int j = 0; j < NSTEP; j++) begin
      logic [7:0] rs = 8'd0;
      for (int r = 0; r < NR; r++) begin
        if (ends[r] > rs) begin
          eCode[nExp] = expCode(j);
          eRank[nExp] = r;
          eStep[nExp] = j;
          eAddr[nExp] = (longint'(rs) << US) + expOff(j);
          nExp++;
          rs = ends[r];
        end
      end
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", {tag, " busy after start"}, busy, 1);
    check(modeSel == 3'd1, "R2", {tag, " first code NOP"}, modeSel, 1);
    for (int cyc = 1; cyc <= 6000; cyc++) begin
      @(negedge clk);
      start = (cyc == injectAt);
      if (cmdValid) begin
        if (modeSel == 3'd7) badNormal = 1;
        if (nAct < 64) begin
          aCode[nAct] = modeSel; aRank[nAct] = cmdRank;
          aAddr[nAct] = cmdAddr; aCyc[nAct] = cyc;
        end
        nAct++;
      end
      if (modeSel == 3'd7 && t7 < 0) t7 = cyc;
      if (initDone) begin
        tDone = cyc;
        break;
      end
    end
    start = 1'b0;
    check(tDone >= 0, "R9", {tag, " watchdog: initDone reached"}, tDone, 1);
    check(!badNormal, "R7", {tag, " no strobe in normal mode"}, badNormal, 0);
    check(nAct == nExp, "R6", {tag, " strobe count"}, nAct, nExp);
    for (int i = 0; i < nExp && i < nAct; i++) begin
      check(aCode[i] == eCode[i], "R2", $sformatf("%s code #%0d", tag, i), aCode[i], eCode[i]);
      check(aRank[i] == eRank[i], "R5", $sformatf("%s rank #%0d", tag, i), aRank[i], eRank[i]);
      check(aAddr[i] == eAddr[i], "R4", $sformatf("%s addr #%0d", tag, i), aAddr[i], eAddr[i]);
      if (i > 0) begin
        int g;
        if (eStep[i] == eStep[i-1]) g = eRank[i] - eRank[i-1];
        else g = (NR - 1 - eRank[i-1]) + ((eStep[i-1] == 0) ? LW : SW) + 1 + eRank[i];
        check(aCyc[i] - aCyc[i-1] == g, "R8", $sformatf("%s gap #%0d", tag, i),
              aCyc[i] - aCyc[i-1], g);
      end
    end
    check(tDone - t7 == SW, "R9", {tag, " normal-to-done cycles"}, tDone - t7, SW);
    check(busy == 1'b0, "R9", {tag, " busy low at done"}, busy, 0);
    check(modeSel == 3'd7, "R9", {tag, " modeSel normal at done"}, modeSel, 7);
  endtask

  task automatic testDoneIgnoresStart();
    bit sawCmd = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (cmdValid || busy) sawCmd = 1;
    end
    check(!sawCmd, "R10", "start after done ignored", sawCmd, 0);
    check(initDone == 1'b1, "R9", "initDone held", initDone, 1);
  endtask

  initial begin
    testReset();
    // R3 R4 R5 R6 R10: rank 1 equals running start, restart pulse mid-run
    runSeq(8'd4, 8'd4, 8'd8, 8'd12, 60, "full");
    testDoneIgnoresStart();
    runSeq(8'd0, 8'd0, 8'd0, 8'd6, -1, "single");
    runSeq(8'd0, 8'd0, 8'd0, 8'd0, -1, "empty");
    runSeq(8'd2, 8'd3, 8'd5, 8'd9, -1, "dense");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule